// File: doc/BRIEF.md
# Automatic Crossover Resolution Controller

This block chooses whether a twisted-pair port uses straight-through pairing or crossed-over pairing, and holds the 16-bit management register that steers that choice. In automatic mode it holds one pairing for a programmable slot time. When a slot runs out with no receive activity it flips to the other pairing and starts a new slot. Once activity arrives it locks the pairing and raises a completion flag. With automatic mode off, a manual select bit sets the pairing directly.

The analog pair switch and link-pulse detection are outside the block. Receive activity and link loss reach it as digital inputs. The register port is a plain synchronous bus: a write strobe that is already address-qualified, 16-bit write data, and read data produced combinationally. The slot length in clock ticks comes from a tick-per-millisecond parameter, so simulation can run with short slots.

Top module: `xover_ctrl`

## Requirements
- R1: Register bits 15:8 always read 0, and the values written to them have no effect.
- R2: After reset the register reads 0x0080: automatic mode 1, manual select 0, pairing 0, complete 0, slot code 0. The pairing output is 0 (straight-through).
- R3: Bit 7 (automatic enable), bit 6 (manual select, 1 = crossover) and bits 3:0 (slot code) read back the last value written to them.
- R4: Read bit 5 always equals the pairing output (1 = crossover). Read bit 4 is the completion flag.
- R5: In automatic mode, with no activity, the pairing toggles exactly S clock edges after a restart and again every S edges after that. S = floor((80*15*T + code*25*T)/15), where T is ticks per millisecond. This gives 80 ms at code 0 and 105 ms at code 15.
- R6: Activity sampled during a running slot sets the completion flag at that edge. The pairing then stays frozen for as long as the flag is set.
- R7: When activity arrives in the very cycle that a slot runs out, the lock takes priority: the pairing does not toggle and the flag sets.
- R8: A link-loss pulse clears the flag. The search then restarts from the current pairing with a full slot counted from that edge.
- R9: In automatic mode any register write clears the flag and restarts the slot timer from that write edge.
- R10: With bit 7 cleared, the pairing equals bit 6 from the second edge after the write. In this mode the flag stays 0, activity has no effect and no toggling occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Address-matched register write strobe |
| wr_data | input | 16 | Register write data |
| rd_data | output | 16 | Register read data (combinational) |
| link_act | input | 1 | Valid receive activity seen on the wire |
| link_loss | input | 1 | Link lost pulse |
| pair_x | output | 1 | Applied pairing, 1 = crossover, registered |

## Verification
The one real collision is between slot expiry and arriving activity. Both can fall on the same clock edge, and then the pairing may toggle or it may lock. The bench counts edges from a register write to reach the exact cycle in which the slot counter sits at its last value. It raises activity in that cycle and then requires the pairing to be unchanged with the flag set. A second overlap is a register write, or a link-loss pulse, arriving while the pairing is locked. There the bench requires the flag to clear and the next toggle to come exactly one full slot later.

// File: rtl/xover_pkg.sv
package xover_pkg;
  // slot length in ticks for a 4-bit code, linear from 80 ms to 105 ms
  function automatic int unsigned slot_ticks(input logic [3:0] code, input int unsigned tpm);
    return 80 * tpm + (int'(code) * 25 * tpm) / 15;
  endfunction

  function automatic int unsigned cnt_width(input int unsigned tpm);
    int unsigned w;
    w = 1;
    while ((1 << w) <= slot_ticks(4'hF, tpm)) w++;
    return w;
  endfunction
endpackage

// File: rtl/xover_regs.sv
module xover_regs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  input  logic        pair_x,
  input  logic        done,
  output logic        auto_en,
  output logic        man_sel,
  output logic [3:0]  slot_code,
  output logic [15:0] rd_data
);
  logic unused_wr_bits;
  assign unused_wr_bits = ^{wr_data[15:8], wr_data[5:4]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      auto_en   <= 1'b1;
      man_sel   <= 1'b0;
      slot_code <= 4'd0;
    end else if (wr_en) begin
      auto_en   <= wr_data[7];
      man_sel   <= wr_data[6];
      slot_code <= wr_data[3:0];
    end
  end

  assign rd_data = {8'h00, auto_en, man_sel, pair_x, done, slot_code};
endmodule

// File: rtl/xover_slot_timer.sv
module xover_slot_timer #(
  parameter int unsigned TICKS_PER_MS = 125000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic [3:0] slot_code,
  output logic       expire,
  output logic [xover_pkg::cnt_width(TICKS_PER_MS)-1:0] slot_cnt
);
  import xover_pkg::*;
  localparam int unsigned CNT_W = cnt_width(TICKS_PER_MS);

  logic [CNT_W-1:0] last_val;
  assign last_val = CNT_W'(slot_ticks(slot_code, TICKS_PER_MS) - 1);

  assign expire = run && !restart && (slot_cnt == last_val);

  always_ff @(posedge clk) begin
    if (!rst_n)                         slot_cnt <= '0;
    else if (restart || !run || expire) slot_cnt <= '0;
    else                                slot_cnt <= slot_cnt + 1'b1;
  end
endmodule

// File: rtl/xover_pair_fsm.sv
module xover_pair_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic auto_en,
  input  logic man_sel,
  input  logic restart,
  input  logic link_act,
  input  logic expire,
  output logic pair_x,
  output logic done
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pair_x <= 1'b0;
      done   <= 1'b0;
    end else if (!auto_en) begin
      pair_x <= man_sel;
      done   <= 1'b0;
    end else if (restart) begin
      done   <= 1'b0;
    end else if (!done && link_act) begin
      done   <= 1'b1;          // lock wins over a same-cycle expiry
    end else if (expire) begin
      pair_x <= ~pair_x;
    end
  end
endmodule

// File: rtl/xover_ctrl.sv
module xover_ctrl #(
  parameter int unsigned TICKS_PER_MS = 125000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  input  logic        link_act,
  input  logic        link_loss,
  output logic        pair_x
);
  localparam int unsigned CNT_W = xover_pkg::cnt_width(TICKS_PER_MS);

  logic             auto_en;
  logic             man_sel;
  logic [3:0]       slot_code;
  logic             done;
  logic             slot_expire;
  logic             slot_run;
  logic             search_restart;
  logic [CNT_W-1:0] slot_cnt;

  assign slot_run       = auto_en && !done;
  assign search_restart = wr_en || link_loss;

  xover_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .pair_x(pair_x), .done(done), .auto_en(auto_en), .man_sel(man_sel),
    .slot_code(slot_code), .rd_data(rd_data)
  );

  xover_slot_timer #(.TICKS_PER_MS(TICKS_PER_MS)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(slot_run), .restart(search_restart),
    .slot_code(slot_code), .expire(slot_expire), .slot_cnt(slot_cnt)
  );

  xover_pair_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .man_sel(man_sel),
    .restart(search_restart), .link_act(link_act), .expire(slot_expire),
    .pair_x(pair_x), .done(done)
  );
endmodule

// File: rtl/xover_chk.sv
module xover_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             link_loss,
  input logic [15:0]      rd_data,
  input logic             pair_x,
  input logic             auto_en,
  input logic             man_sel,
  input logic             done,
  input logic             slot_expire,
  input logic             slot_run,
  input logic [CNT_W-1:0] slot_cnt
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) rd_data[15:8] == 8'h00); // R1
  AST_PAIR_MIRROR: assert property (@(posedge clk) disable iff (!rst_n) rd_data[5] == pair_x); // R4
  AST_HOLD_NO_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n) (auto_en && !slot_expire) |=> $stable(pair_x)); // R5
  AST_EXPIRE_SEARCHING: assert property (@(posedge clk) disable iff (!rst_n) slot_expire |-> (auto_en && !done)); // R6
  AST_LOCK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) (done && !wr_en && !link_loss) |=> (done && $stable(pair_x))); // R6
  AST_LOSS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) link_loss |=> !done); // R8
  AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) wr_en |=> !done); // R9
  AST_TIMER_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !slot_run |=> (slot_cnt == '0)); // R9
  AST_MANUAL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n) !auto_en |=> (pair_x == $past(man_sel))); // R10
  AST_MANUAL_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n) !auto_en |-> !done); // R10
endmodule

bind xover_ctrl xover_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .link_loss(link_loss),
  .rd_data(rd_data), .pair_x(pair_x), .auto_en(auto_en), .man_sel(man_sel),
  .done(done), .slot_expire(slot_expire), .slot_run(slot_run), .slot_cnt(slot_cnt)
);

// File: tb/sim_xover_ctrl.sv
`timescale 1ns/1ps
module sim_xover_ctrl;
  localparam int unsigned TPM = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        link_act = 1'b0;
  logic        link_loss = 1'b0;
  logic        pair_x;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  xover_ctrl #(.TICKS_PER_MS(TPM)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .link_act(link_act), .link_loss(link_loss), .pair_x(pair_x)
  );

  // slot length restated: 80 ms plus code * 5/3 ms, in ticks
  function automatic int exp_slot(input int code);
    return (1200 * TPM + code * 25 * TPM) / 15;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  // write across one posedge; returns at the negedge right after it
  task automatic wr(input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  // counts edges until pair_x changes (caller is at negedge after a restart edge)
  task automatic edges_to_toggle(output int n);
    logic p0;
    p0 = pair_x;
    n = 0;
    while (pair_x == p0 && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    int n;
    logic p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd_data == 16'h0080, "R2 reset register", rd_data, 16'h0080);
    chk(pair_x == 1'b0, "R2 reset pairing", pair_x, 0);

    // R5: sweep every slot code
    for (int c = 0; c < 16; c++) begin
      wr(16'h0080 | 16'(c));
      edges_to_toggle(n);
      chk(n == exp_slot(c), $sformatf("R5 slot code %0d", c), n, exp_slot(c));
      chk(rd_data[5] == pair_x, "R4 pairing bit mirror", rd_data[5], pair_x);
    end
    // second toggle arrives one full slot later (code 15 still set)
    edges_to_toggle(n);
    chk(n == exp_slot(15), "R5 periodic toggle", n, exp_slot(15));

    // R6: lock on activity
    wr(16'h0082);
    repeat (100) @(negedge clk);
    link_act = 1'b1; @(negedge clk); link_act = 1'b0;
    chk(rd_data[4] == 1'b1, "R6 complete flag", rd_data[4], 1);
    p = pair_x;
    repeat (600) @(negedge clk);
    chk(pair_x == p && rd_data[4], "R6 pairing frozen", pair_x, p);

    // R9: write while locked clears flag and restarts search
    wr(16'h0082);
    chk(rd_data[4] == 1'b0, "R9 write clears flag", rd_data[4], 0);
    edges_to_toggle(n);
    chk(n == exp_slot(2), "R9 full slot after write", n, exp_slot(2));

    // R7: activity in the expiry cycle
    wr(16'h0080);
    p = pair_x;
    repeat (exp_slot(0) - 1) @(negedge clk);
    link_act = 1'b1; @(negedge clk); link_act = 1'b0;
    chk(pair_x == p, "R7 no toggle on collision", pair_x, p);
    chk(rd_data[4] == 1'b1, "R7 lock on collision", rd_data[4], 1);

    // R8: link loss resumes search from current pairing
    repeat (20) @(negedge clk);
    p = pair_x;
    link_loss = 1'b1; @(negedge clk); link_loss = 1'b0;
    chk(rd_data[4] == 1'b0 && pair_x == p, "R8 loss clears flag", rd_data[4], 0);
    edges_to_toggle(n);
    chk(n == exp_slot(0), "R8 full slot after loss", n, exp_slot(0));
    chk(pair_x == ~p, "R8 toggled from current", pair_x, ~p);

    // R10 + R3 + R1: manual crossover, reserved bits set
    wr(16'hFF4A);
    @(negedge clk);
    chk(pair_x == 1'b1, "R10 manual crossover", pair_x, 1);
    chk(rd_data == 16'h006A, "R3 readback manual", rd_data, 16'h006A);
    chk(rd_data[15:8] == 8'h00, "R1 reserved read zero", rd_data[15:8], 0);
    link_act = 1'b1; @(negedge clk); link_act = 1'b0;
    chk(rd_data[4] == 1'b0 && pair_x, "R10 activity ignored", rd_data[4], 0);
    wr(16'hA505);
    @(negedge clk);
    chk(pair_x == 1'b0, "R10 manual straight", pair_x, 0);
    chk(rd_data == 16'h0005, "R1 R3 readback", rd_data, 16'h0005);
    repeat (400) @(negedge clk);
    chk(pair_x == 1'b0 && rd_data[4] == 1'b0, "R10 no toggling in manual", pair_x, 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule